// File: doc/BRIEF.md
# Windowed Power Ramp Envelope Generator

This block shapes the power of a transmitted sample stream at the edges of a time slot. On a command it produces a rising or a falling envelope that follows a two-term cosine window (Blackman) or a one-term cosine window (Hanning). Between ramps it holds the envelope at the value reached by the last ramp. Each incoming data sample is multiplied by the current envelope, and the product is rounded and saturated back to the data width.

The window comes from two second-order recursive resonators plus a constant bias, not from a stored table. The host works out the resonator coefficients (2cos θ), their two seed samples and the bias. These values set both the ramp length and the final power level. The block reloads the resonator state from those seeds at every ramp command, so rounding error cannot build up from one slot to the next. A sample counter loaded with the ramp length in samples ends the ramp. At that point the envelope freezes and a done flag rises.

All fixed-point words use 24 fractional bits (1.0 = 2^24). There is one sample per clock.

Top module: `bkm_ramp_scaler`

## Requirements
- R1: After reset, `env` = 0, `dout` = 0, `ramp_active` = 0 and `ramp_done` = 0.
- R2: Each resonator advances as next = trunc27(floor(k·cur / 2^24)) − prev. Here k is a signed 27-bit coefficient with 24 fraction bits, the states are signed 27-bit, and the subtraction wraps modulo 2^27.
- R3: When `start` is sampled high, resonator 1 is seeded with (`osc1_s0`, `osc1_s1`), negated when `go_up` = 1. Resonator 2 is seeded with (`osc2_s0`, `osc2_s1`), or with zeros when `one_term` = 1. `ramp_active` is 1 and `ramp_done` is 0 after that edge, and `env` does not change at that edge.
- R4: On each clock edge during a ramp, `env` takes the sum of both resonators' current samples plus `env_bias`, modulo 2^27. Over a ramp it therefore shows x(0) through x(N).
- R5: With `ramp_len` = N, `env` is updated on exactly N+1 edges after the start edge. `ramp_active` falls and `ramp_done` rises on the edge of the last update. N = 0 gives a single update. The two flags are never high together.
- R6: While no ramp is running and `start` is low, `env` holds its value.
- R7: `dout` is registered one cycle after `din`. It equals floor((din·env + 2^23) / 2^24), which rounds halves toward plus infinity.
- R8: A scaled result above 8191 gives 8191, and one below −8192 gives −8192.
- R9: A `start` during a running ramp discards that ramp, reseeds both resonators and reloads the counter. A `start` after a completed ramp clears `ramp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Ramp command, sampled at a clock edge |
| go_up | input | 1 | 1 = rising ramp (resonator 1 seeds negated), 0 = falling |
| one_term | input | 1 | 1 = Hanning (resonator 2 seeded with zeros) |
| ramp_len | input | 16 | Ramp length N in samples |
| osc1_k | input | 27 | Resonator 1 coefficient 2cos θ1 |
| osc2_k | input | 27 | Resonator 2 coefficient 2cos θ2 |
| osc1_s0 | input | 27 | Resonator 1 seed x(0) (falling polarity) |
| osc1_s1 | input | 27 | Resonator 1 seed x(1) (falling polarity) |
| osc2_s0 | input | 27 | Resonator 2 seed x(0) |
| osc2_s1 | input | 27 | Resonator 2 seed x(1) |
| env_bias | input | 27 | Constant added to the resonator sum |
| din | input | 14 | Signed data sample |
| dout | output | 14 | Scaled, rounded and saturated sample |
| env | output | 27 | Current envelope word |
| ramp_active | output | 1 | High while a ramp is running (hold path deselected) |
| ramp_done | output | 1 | High after a ramp has completed |

## Verification
A corrupted resonator state shows on `env` on the edge after the corruption. It then spreads to every later sample of the ramp, so the final held level misses its target: near zero for a falling ramp and near the amplitude for a rising one. A counter that is off by one shows as an extra or a missing `env` update and as a shift in the edge at which `ramp_done` rises. Both are visible the same cycle. Errors in the multiplier, the rounding or the saturation appear on `dout` one cycle after the matching `din`. The rounding cases at ±0.5 and ±1.5 and the clamps at both rails separate them.

// File: rtl/bkm_ramp_scaler.sv
module bkm_ramp_scaler #(
  parameter int SW = 27,
  parameter int FB = 24,
  parameter int DW = 14,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 go_up,
  input  logic                 one_term,
  input  logic        [CW-1:0] ramp_len,
  input  logic signed [SW-1:0] osc1_k,
  input  logic signed [SW-1:0] osc2_k,
  input  logic signed [SW-1:0] osc1_s0,
  input  logic signed [SW-1:0] osc1_s1,
  input  logic signed [SW-1:0] osc2_s0,
  input  logic signed [SW-1:0] osc2_s1,
  input  logic signed [SW-1:0] env_bias,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout,
  output logic signed [SW-1:0] env,
  output logic                 ramp_active,
  output logic                 ramp_done
);
  localparam int PW = 2 * SW;
  localparam int MW = DW + SW;
  localparam logic signed [MW-1:0] HALF = MW'(1) << (FB - 1);
  localparam logic signed [MW-1:0] HI   = MW'((1 << (DW - 1)) - 1);
  localparam logic signed [MW-1:0] LO   = -HI - MW'(1);

  logic signed [SW-1:0] a1, b1, a2, b2, env_q, nx1, nx2;
  logic        [CW-1:0] cnt;
  logic                 act, done;
  logic signed [MW-1:0] prod, shd;
  logic signed [DW-1:0] dout_q, sat;

  function automatic logic signed [SW-1:0] resonate(
    input logic signed [SW-1:0] k,
    input logic signed [SW-1:0] cur,
    input logic signed [SW-1:0] prv
  );
    logic signed [PW-1:0] p;
    p = $signed({{SW{k[SW-1]}}, k}) * $signed({{SW{cur[SW-1]}}, cur});
    p = p >>> FB;
    return p[SW-1:0] - prv;
  endfunction

  assign nx1 = resonate(osc1_k, b1, a1);
  assign nx2 = resonate(osc2_k, b2, a2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1 <= '0; b1 <= '0; a2 <= '0; b2 <= '0;
      env_q <= '0; cnt <= '0; act <= 1'b0; done <= 1'b0;
    end else if (start) begin
      a1   <= go_up ? -osc1_s0 : osc1_s0;
      b1   <= go_up ? -osc1_s1 : osc1_s1;
      a2   <= one_term ? '0 : osc2_s0;
      b2   <= one_term ? '0 : osc2_s1;
      cnt  <= ramp_len;
      act  <= 1'b1;
      done <= 1'b0;
    end else if (act) begin
      env_q <= a1 + a2 + env_bias;
      a1 <= b1; b1 <= nx1;
      a2 <= b2; b2 <= nx2;
      if (cnt == '0) begin
        act  <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign prod = $signed({{SW{din[DW-1]}}, din}) * $signed({{DW{env_q[SW-1]}}, env_q});
  assign shd  = (prod + HALF) >>> FB;
  assign sat  = (shd > HI) ? HI[DW-1:0] : (shd < LO) ? LO[DW-1:0] : shd[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= sat;
  end

  assign dout        = dout_q;
  assign env         = env_q;
  assign ramp_active = act;
  assign ramp_done   = done;
endmodule

module bkm_ramp_scaler_chk #(
  parameter int SW = 27,
  parameter int DW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic signed [DW-1:0] din,
  input logic signed [DW-1:0] dout,
  input logic signed [SW-1:0] env,
  input logic                 ramp_active,
  input logic                 ramp_done
);
  // R3
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ramp_active && !ramp_done));
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_active && ramp_done));
  // R5
  done_follows_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_done) |-> $past(ramp_active));
  // R6
  env_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_active && !start) |=> $stable(env));
  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din == '0) |=> (dout == '0));
endmodule

bind bkm_ramp_scaler bkm_ramp_scaler_chk #(.SW(SW), .DW(DW)) u_chk (.*);

// File: tb/bkm_ramp_scaler_tb.sv
module bkm_ramp_scaler_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, go_up, one_term;
  logic [15:0] ramp_len;
  logic signed [26:0] osc1_k, osc2_k, osc1_s0, osc1_s1, osc2_s0, osc2_s1, env_bias, env;
  logic signed [13:0] din, dout;
  logic ramp_active, ramp_done;

  bkm_ramp_scaler u_dut (.*);

  typedef struct {
    logic signed [26:0] env;
    logic signed [13:0] dout;
    logic act;
    logic done;
    string req;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic signed [26:0] m_a1, m_b1, m_a2, m_b2, m_env;
  logic signed [13:0] m_dout;
  logic [15:0] m_cnt;
  logic m_act, m_done;

  task automatic chk(input bit ok, input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic logic signed [26:0] res_model(input logic signed [26:0] k, input logic signed [26:0] cur, input logic signed [26:0] prv);
    longint p;
    p = longint'(k) * longint'(cur);
    p = p >>> 24;
    return 27'(p) - prv;
  endfunction

  function automatic logic signed [26:0] q24(input real r);
    return 27'($rtoi(r * 16777216.0 + ((r >= 0.0) ? 0.5 : -0.5)));
  endfunction

  task automatic step(input string req);
    exp_t e;
    longint p;
    logic signed [26:0] t1, t2;
    p = longint'(din) * longint'(m_env);
    p = (p + 64'sd8388608) >>> 24;
    if (p > 8191) p = 8191;
    if (p < -8192) p = -8192;
    if (start) begin
      m_a1 = go_up ? -osc1_s0 : osc1_s0;
      m_b1 = go_up ? -osc1_s1 : osc1_s1;
      m_a2 = one_term ? 27'sd0 : osc2_s0;
      m_b2 = one_term ? 27'sd0 : osc2_s1;
      m_cnt = ramp_len; m_act = 1; m_done = 0;
    end else if (m_act) begin
      m_env = m_a1 + m_a2 + env_bias;
      t1 = res_model(osc1_k, m_b1, m_a1);
      t2 = res_model(osc2_k, m_b2, m_a2);
      m_a1 = m_b1; m_b1 = t1; m_a2 = m_b2; m_b2 = t2;
      if (m_cnt == 0) begin m_act = 0; m_done = 1; end
      else m_cnt = m_cnt - 1;
    end
    m_dout = 14'(p);
    e.env = m_env; e.dout = m_dout; e.act = m_act; e.done = m_done; e.req = req;
    @(posedge clk);
    q.push_back(e);
    #1;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(env == e.env, e.req, "env", env, e.env);
      chk(dout == e.dout, e.req, "dout", dout, e.dout);
      chk(ramp_active == e.act, e.req, "ramp_active", ramp_active, e.act);
      chk(ramp_done == e.done, e.req, "ramp_done", ramp_done, e.done);
    end
  end

  task automatic setup(input real amp, input int n, input bit up, input bit one, input real bias);
    real pi;
    pi = 3.14159265358979;
    osc1_k  = q24(2.0 * $cos(pi / n));
    osc2_k  = q24(2.0 * $cos(2.0 * pi / n));
    osc1_s0 = q24(0.5 * amp);
    osc1_s1 = q24(0.5 * amp * $cos(pi / n));
    osc2_s0 = q24(0.08 * amp);
    osc2_s1 = q24(0.08 * amp * $cos(2.0 * pi / n));
    env_bias = q24(bias);
    ramp_len = 16'(n);
    go_up = up;
    one_term = one;
  endtask

  task automatic run_ramp(input string req, input int extra);
    start = 1;
    step(req);
    start = 0;
    for (int i = 0; i <= int'(ramp_len) + extra; i++) step(req);
  endtask

  task automatic near(input string req, input longint target, input longint tol);
    @(negedge clk);
    chk((longint'(env) - target <= tol) && (target - longint'(env) <= tol), req, "final env", env, target);
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; go_up = 0; one_term = 0; ramp_len = 0; din = 0;
    osc1_k = 0; osc2_k = 0; osc1_s0 = 0; osc1_s1 = 0; osc2_s0 = 0; osc2_s1 = 0; env_bias = 0;
    m_a1 = 0; m_b1 = 0; m_a2 = 0; m_b2 = 0; m_env = 0; m_dout = 0; m_cnt = 0; m_act = 0; m_done = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(env == 0, "R1", "env", env, 0);
    chk(dout == 0, "R1", "dout", dout, 0);
    chk(ramp_active == 0, "R1", "ramp_active", ramp_active, 0);
    chk(ramp_done == 0, "R1", "ramp_done", ramp_done, 0);
    @(posedge clk); #1;

    // R2 R4 R5 falling Blackman, amplitude 1.0
    din = 4096;
    setup(1.0, 16, 0, 0, 0.42);
    run_ramp("R4", 0);
    near("R4", 0, 1024);
    // R6 hold with changing data
    din = -5000; step("R6"); din = 1234; step("R6"); step("R6");

    // R3 rising Blackman ends at amplitude
    din = 3000;
    setup(1.0, 16, 1, 0, 0.42);
    run_ramp("R3", 2);
    near("R3", 16777216, 1024);

    // R3 Hanning: resonator 2 seeds ignored, falling to zero
    setup(1.0, 12, 0, 1, 0.5);
    run_ramp("R3", 1);
    near("R3", 0, 1024);

    // R8 saturation at both rails with amplitude 3.0
    setup(3.0, 10, 1, 0, 1.26);
    din = 8000;
    run_ramp("R8", 0);
    din = 8000; step("R8");
    din = -8000; step("R8");
    din = 8191; step("R8");
    din = -8192; step("R8");
    step("R8");

    // R5 R7 zero-length ramp, exact envelope 0.25, rounding of halves
    setup(1.0, 8, 0, 1, 0.0);
    osc1_s0 = 27'sd4194304;
    ramp_len = 0;
    din = 0;
    run_ramp("R5", 0);
    din = 2;  step("R7");
    din = -2; step("R7");
    din = 6;  step("R7");
    din = -6; step("R7");
    din = 0;  step("R7");

    // R9 restart mid-ramp and start after done
    din = 2000;
    setup(1.0, 16, 0, 0, 0.42);
    start = 1; step("R9"); start = 0;
    repeat (5) step("R9");
    setup(1.0, 16, 1, 0, 0.42);
    run_ramp("R9", 1);
    near("R9", 16777216, 1024);

    repeat (2) step("R6");
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule